// File: doc/BRIEF.md
# RS-485 Transceiver Direction Controller

This block sits next to a UART transmitter and drives the direction-enable pin of an external RS-485 line driver. The transmitter tells it two things: that data is waiting or shifting (`tx_pending`), and that the final stop bit of a character has just left the line (`tx_last_stop`, a one-cycle pulse). The block turns the line driver on when data appears. When the transmitter is done, it keeps the driver on for a set number of baud periods, then turns it off. This gives the far end time to see a clean end of frame before the bus is released.

The configuration inputs come from a register block that is not part of this design. They are an enable for automatic control, a polarity select that picks which logic level means "driving", and an 8-bit hold-off value counted in baud ticks. The baud tick is a single-cycle strobe from the UART's bit-rate generator. The hold-off is timed by a down-counter that loads when the last stop bit leaves and counts down only on tick cycles. If new data arrives during the hold-off, the countdown is dropped and the driver stays on without a gap.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `dir_out` is at the released level for the current polarity: 1 when `pol_invert` = 0, and 0 when `pol_invert` = 1.
- R2: While `auto_en` = 0, `dir_out` stays at the released level for the current polarity, whatever happens on `tx_pending`, `tx_last_stop` and `baud_tick`.
- R3: With `pol_invert` = 0, the driving level of `dir_out` is 0 and the released level is 1.
- R4: With `pol_invert` = 1, the driving level of `dir_out` is 1 and the released level is 0.
- R5: `dir_out` is registered. When `auto_en` = 1 and `tx_pending` is sampled high at a clock edge, `dir_out` is at the driving level from that edge on.
- R6: With a hold-off value N in 1..255, the hold-off starts at the edge where `tx_last_stop` = 1 and `tx_pending` = 0 are sampled while driving. `dir_out` stays at the driving level until the edge that samples the Nth `baud_tick` after that edge. At that edge it returns to the released level. A tick in the same cycle as the stop pulse is not counted.
- R7: With a hold-off value of 0, `dir_out` returns to the released level at the edge that samples `tx_last_stop` = 1 with `tx_pending` = 0.
- R8: If `tx_pending` is sampled high during a hold-off, the countdown is abandoned and `dir_out` stays at the driving level on every cycle. A later stop pulse starts a fresh countdown from the full value.
- R9: A change to `hold_dly` during a countdown does not alter that countdown. The value sampled with the stop pulse is the one used.
- R10: A `tx_last_stop` pulse while released, or while `tx_pending` is still high, does not release the driver or start a countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Enables automatic direction control |
| pol_invert | input | 1 | 0: drive low while sending; 1: drive high while sending |
| hold_dly | input | 8 | Hold-off after the last stop bit, in baud ticks (0..255) |
| baud_tick | input | 1 | Single-cycle baud-period strobe |
| tx_pending | input | 1 | Transmitter has data queued or shifting |
| tx_last_stop | input | 1 | One-cycle pulse when the last stop bit has left |
| dir_out | output | 1 | Registered direction-enable output to the line driver |

## Verification
The bench runs single frames with a zero hold-off and with non-zero hold-offs, under both polarities and with sparse and dense baud ticks. These runs separate an immediate release from a counted one, and show the tick that ends the hold-off. Further patterns exercise the corner cases:
- new data arriving in the middle of a hold-off, which shows whether the countdown is cancelled without a glitch;
- the hold-off value changing during a countdown, which shows whether the loaded copy is the one used;
- stop pulses arriving while idle or while data is still pending, which shows whether these are ignored;
- a tick coinciding with the stop pulse, which shows whether such a tick is wrongly counted.

A long stretch of pseudo-random pending, stop and tick activity, with the enable toggled and the hold-off value changed, is compared cycle by cycle against a behavioural model. This finds ordering faults that the directed cases miss.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    // Controller phase: released, driving for data, or driving during hold-off
    typedef enum logic [1:0] {
        DIR_IDLE   = 2'd0,
        DIR_ACTIVE = 2'd1,
        DIR_HOLD   = 2'd2
    } dir_state_e;

    typedef struct packed {
        logic auto_en;
        logic invert;
    } dir_cfg_t;

    typedef struct packed {
        logic pending;
        logic last_stop;
        logic tick;
    } tx_evt_t;

    // Pin level for a given drive request and polarity
    function automatic logic dir_level(input logic drive, input logic invert);
        return drive ? invert : ~invert;
    endfunction

endpackage

// File: rtl/rs485_holdoff_cnt.sv
module rs485_holdoff_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cancel,
    input  logic             tick,
    output logic             expire,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Last tick of a running countdown
    assign expire = tick && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
    import rs485_dir_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  dir_cfg_t         cfg,
    input  logic [DLY_W-1:0] dly,
    input  tx_evt_t          evt,
    input  logic             expire,
    output logic             load,
    output logic             cancel,
    output logic             drive_next,
    output dir_state_e       state_q
);
    dir_state_e state_d;
    logic       finish;

    assign finish = evt.last_stop && !evt.pending;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        cancel  = 1'b0;
        if (!cfg.auto_en) begin
            state_d = DIR_IDLE;
            cancel  = 1'b1;
        end else begin
            unique case (state_q)
                DIR_IDLE: begin
                    if (evt.pending) state_d = DIR_ACTIVE;
                end
                DIR_ACTIVE: begin
                    if (finish) begin
                        if (dly == '0) begin
                            state_d = DIR_IDLE;
                        end else begin
                            state_d = DIR_HOLD;
                            load    = 1'b1;
                        end
                    end
                end
                DIR_HOLD: begin
                    if (evt.pending) begin
                        state_d = DIR_ACTIVE;
                        cancel  = 1'b1;
                    end else if (expire) begin
                        state_d = DIR_IDLE;
                    end
                end
                default: begin
                    state_d = DIR_IDLE;
                    cancel  = 1'b1;
                end
            endcase
        end
    end

    assign drive_next = (state_d != DIR_IDLE);

    always_ff @(posedge clk) begin
        if (rst) state_q <= DIR_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/rs485_dir_drv.sv
module rs485_dir_drv
    import rs485_dir_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dir_cfg_t cfg,
    input  logic     drive_next,
    output logic     pin_q
);
    always_ff @(posedge clk) begin
        if (rst) pin_q <= dir_level(1'b0, cfg.invert);
        else     pin_q <= dir_level(drive_next && cfg.auto_en, cfg.invert);
    end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic             pol_invert,
    input  logic [DLY_W-1:0] hold_dly,
    input  logic             baud_tick,
    input  logic             tx_pending,
    input  logic             tx_last_stop,
    output logic             dir_out
);
    dir_cfg_t         cfg;
    tx_evt_t          evt;
    dir_state_e       state_q;
    logic             load, cancel, expire, drive_next;
    logic [DLY_W-1:0] cnt_q;

    assign cfg = '{auto_en: auto_en, invert: pol_invert};
    assign evt = '{pending: tx_pending, last_stop: tx_last_stop, tick: baud_tick};

    rs485_dir_fsm #(.DLY_W(DLY_W)) fsm_i (
        .clk(clk), .rst(rst), .cfg(cfg), .dly(hold_dly), .evt(evt),
        .expire(expire), .load(load), .cancel(cancel),
        .drive_next(drive_next), .state_q(state_q)
    );

    rs485_holdoff_cnt #(.CNT_W(DLY_W)) cnt_i (
        .clk(clk), .rst(rst), .load(load), .load_val(hold_dly),
        .cancel(cancel), .tick(evt.tick), .expire(expire), .cnt_q(cnt_q)
    );

    rs485_dir_drv drv_i (
        .clk(clk), .rst(rst), .cfg(cfg), .drive_next(drive_next), .pin_q(dir_out)
    );
endmodule

// File: rtl/rs485_dir_chk.sv
module rs485_dir_chk
    import rs485_dir_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             auto_en,
    input logic             pol_invert,
    input logic [DLY_W-1:0] hold_dly,
    input logic             baud_tick,
    input logic             tx_pending,
    input logic             tx_last_stop,
    input logic             dir_out,
    input dir_state_e       state_q,
    input logic [DLY_W-1:0] cnt_q
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> dir_out == !$past(pol_invert));

    // R5
    pending_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && tx_pending) |=> dir_out == $past(pol_invert));

    // R7
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && state_q == DIR_ACTIVE && tx_last_stop && !tx_pending && hold_dly == '0)
        |=> dir_out == !$past(pol_invert));

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && state_q == DIR_HOLD && !(baud_tick && cnt_q == ONE))
        |=> dir_out == $past(pol_invert));

    // R10
    idle_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && state_q == DIR_IDLE && !tx_pending)
        |=> dir_out == !$past(pol_invert));
endmodule

bind rs485_dir_ctrl rs485_dir_chk #(.DLY_W(DLY_W)) chk_i (
    .clk(clk), .rst(rst), .auto_en(auto_en), .pol_invert(pol_invert),
    .hold_dly(hold_dly), .baud_tick(baud_tick), .tx_pending(tx_pending),
    .tx_last_stop(tx_last_stop), .dir_out(dir_out), .state_q(state_q), .cnt_q(cnt_q)
);

// File: tb/rs485_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_en = 1'b0;
    logic       pol_invert = 1'b0;
    logic [7:0] hold_dly = 8'd0;
    logic       baud_tick = 1'b0;
    logic       tx_pending = 1'b0;
    logic       tx_last_stop = 1'b0;
    logic       dir_out;

    always #2 clk = ~clk;

    rs485_dir_ctrl dut_i (
        .clk(clk), .rst(rst), .auto_en(auto_en), .pol_invert(pol_invert),
        .hold_dly(hold_dly), .baud_tick(baud_tick), .tx_pending(tx_pending),
        .tx_last_stop(tx_last_stop), .dir_out(dir_out)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    tick_period = 0;
    int    tick_phase = 0;
    string tag = "R1";

    // Behavioural model: 0 released, 1 sending, 2 hold-off with a remaining count
    int mode = 0;
    int remain = 0;
    bit exp_pin = 1'b1;

    task automatic model_edge();
        if (rst || !auto_en) begin
            mode = 0;
            remain = 0;
        end else if (mode == 0) begin
            if (tx_pending) mode = 1;
        end else if (mode == 1) begin
            if (tx_last_stop && !tx_pending) begin
                if (hold_dly == 0) mode = 0;
                else begin mode = 2; remain = hold_dly; end
            end
        end else begin
            if (tx_pending) mode = 1;
            else if (baud_tick) begin
                remain = remain - 1;
                if (remain == 0) mode = 0;
            end
        end
        exp_pin = (mode != 0) ? pol_invert : !pol_invert;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_vec++;
        if (dir_out !== exp_pin) begin
            n_bad++;
            $display("FAIL %s: dir_out=%0b expected=%0b at t=%0t", tag, dir_out, exp_pin, $time);
        end
        tx_last_stop = 1'b0;
        tick_phase++;
        baud_tick = (tick_period > 0) && (tick_phase % tick_period == 0);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Send a frame: pending for len cycles, then the stop pulse, then wait
    task automatic frame(input int len, input int wait_n);
        tx_pending = 1'b1;
        run(len);
        tx_pending = 1'b0;
        tx_last_stop = 1'b1;
        run(wait_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset level for both polarities
        tag = "R1"; rst = 1'b1; run(3);
        pol_invert = 1'b1; run(2);
        pol_invert = 1'b0; run(1);
        rst = 1'b0; run(2);

        // R3 / R7: active-low sense, zero hold-off
        auto_en = 1'b1; tag = "R3"; tick_period = 4;
        frame(6, 4);
        tag = "R7"; frame(2, 3);

        // R6: counted hold-off, sparse ticks
        tag = "R6"; hold_dly = 8'd3; frame(5, 20);
        hold_dly = 8'd1; frame(3, 10);

        // R4: active-high sense
        tag = "R4"; pol_invert = 1'b1; hold_dly = 8'd2; frame(4, 14);
        hold_dly = 8'd0; frame(3, 3);
        pol_invert = 1'b0;

        // R6: tick coincident with the stop pulse is not counted
        tag = "R6"; tick_period = 1; hold_dly = 8'd2; frame(4, 6);

        // R8: new data during hold-off
        tag = "R8"; tick_period = 3; hold_dly = 8'd10;
        frame(3, 7);
        frame(4, 40);

        // R9: delay changed mid-countdown
        tag = "R9"; hold_dly = 8'd5; frame(3, 4);
        hold_dly = 8'd1; run(20);

        // R10: stop pulse while released, and while still pending
        tag = "R10"; tx_last_stop = 1'b1; run(4);
        tx_pending = 1'b1; run(2);
        tx_last_stop = 1'b1; run(3);
        tx_pending = 1'b0; run(1);
        tx_last_stop = 1'b1; hold_dly = 8'd0; run(3);

        // R2: disabled, stimulus has no effect
        tag = "R2"; auto_en = 1'b0;
        frame(5, 5);
        pol_invert = 1'b1; frame(3, 3);
        pol_invert = 1'b0;
        hold_dly = 8'd4; auto_en = 1'b1; frame(2, 1);
        auto_en = 1'b0; run(3); auto_en = 1'b1;

        // R6: full-range hold-off with a tick every cycle
        tag = "R6"; tick_period = 1; hold_dly = 8'd255; frame(3, 262);

        // R5: pseudo-random activity against the model
        tag = "R5"; tick_period = 0;
        for (int i = 0; i < 4000; i++) begin
            tx_pending   = ($urandom_range(0, 3) == 0);
            tx_last_stop = ($urandom_range(0, 4) == 0);
            baud_tick    = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 99) == 0) auto_en = ~auto_en;
            if ($urandom_range(0, 49) == 0) pol_invert = ~pol_invert;
            if ($urandom_range(0, 29) == 0) hold_dly = 8'($urandom_range(0, 6));
            if (i == 3000) rst = 1'b1;
            if (i == 3003) rst = 1'b0;
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule